// File: doc/BRIEF.md
# Interrupt Destination Resolver

The resolver turns one interrupt message into the set of agents that should receive it, for a system of `NUM_AGENTS` agents (eight by default). Each agent presents a physical ID, an 8-bit logical destination and a 4-bit destination model. The agent configuration is supplied on flat input vectors. Agent `i` owns the slice `[i*W +: W]` of each vector.

A message carries these fields:
- a destination byte;
- a physical/logical mode bit;
- a 2-bit shorthand;
- the sender's physical ID;
- a 3-bit delivery mode;
- the level and trigger bits.

The selection is computed combinationally and captured in an output register. The registered result appears one cycle after the message strobe, together with an output valid.

Lowest-priority delivery narrows the selected set to its lowest-indexed member. An INIT message in its de-assert form is not delivered. It instead raises an arbitration-ID resync strobe to each selected agent.

Top module: `intr_dest_resolver`

## Requirements
- R1: In physical mode (`msgLogical`=0) with shorthand 0, a destination of 0xFF selects every agent.
- R2: In physical mode with shorthand 0 and any destination other than 0xFF, the selection is the lowest-indexed agent whose physical ID equals the destination. If no agent's ID matches, nothing is selected.
- R3: In logical mode, an agent with model 0xF (flat) is selected when its logical destination and the message destination share at least one set bit.
- R4: In logical mode, an agent with model 0x0 (cluster) is selected only when both of these hold:
  - bits [7:4] of its logical destination equal bits [7:4] of the message destination;
  - bits [3:0] of the two share at least one set bit.
- R5: In logical mode, an agent whose model is neither 0xF nor 0x0 is never selected.
- R6: Shorthand overrides the destination decode as follows:
  - 0 uses the destination decode;
  - 1 selects every agent whose physical ID equals `senderId`;
  - 2 selects all agents;
  - 3 selects every agent whose ID differs from `senderId`.
- R7: For delivery mode 1 (lowest priority), `targetMask` and `singleTarget` both carry the lowest-indexed selected agent, one-hot. If the selection is empty, both are zero while `outValid` still pulses. For every other mode, `singleTarget` is zero.
- R8: Delivery mode 5 with level bit 0 and trigger bit 1 drives `targetMask` to zero and puts the selection on `resyncMask`. In every other case, `resyncMask` is zero and every mode except 1 passes the selection unchanged to `targetMask`.
- R9: Results appear on the clock edge after a cycle with `msgValid` high, with `outValid` high for exactly that cycle. After a cycle without `msgValid`, `outValid` and all three masks are zero.
- R10: While `rstN` is low, `outValid` and all masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| agentPhysId | input | NUM_AGENTS*8 | Physical ID of each agent |
| agentLogDest | input | NUM_AGENTS*8 | Logical destination of each agent |
| agentModel | input | NUM_AGENTS*4 | Destination model of each agent (0xF flat, 0x0 cluster) |
| msgValid | input | 1 | Message strobe |
| msgDest | input | 8 | Destination byte |
| msgLogical | input | 1 | 1 = logical mode, 0 = physical mode |
| msgShorthand | input | 2 | Shorthand override code |
| senderId | input | 8 | Physical ID of the sending agent |
| msgMode | input | 3 | Delivery mode |
| msgLevel | input | 1 | Level bit |
| msgTrigger | input | 1 | Trigger bit |
| outValid | output | 1 | Result valid |
| targetMask | output | NUM_AGENTS | Agents that receive the message |
| singleTarget | output | NUM_AGENTS | One-hot chosen agent for lowest-priority delivery |
| resyncMask | output | NUM_AGENTS | Agents told to resync their arbitration ID |

## Verification
Two steps can act on the same message in the same cycle:
- the shorthand override, together with the lowest-priority narrowing;
- the shorthand override, together with the INIT resync diversion.

These combinations are provoked by sending:
- a lowest-priority message with the all-but-sender shorthand, where the sender is agent 0;
- an INIT de-assert message carrying the same shorthand.

A correct result narrows or diverts the set only after the sender has been removed. The lowest-priority case must therefore name agent 1, and the resync mask must hold every agent but the sender.

Further cases are:
- a duplicated physical ID, to show that the lowest index wins;
- back-to-back messages followed by an idle cycle, to show that a stale result never lingers.

The bench's behavioural model judges all of these cases on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWEST  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTINT  = 3'd7
  } delivMode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new result this cycle
    logic pickLowest;  // narrow selection to lowest-indexed agent
    logic resyncOnly;  // divert selection to resync strobes
  } routeCtrl_t;

endpackage

// File: rtl/irq_agent_match.sv
module irq_agent_match
  import irq_route_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] physId,
  input  logic [7:0]      logDest,
  input  logic [3:0]      model,
  input  logic [7:0]      msgDest,
  input  logic [ID_W-1:0] senderId,
  output logic            physHit,
  output logic            logHit,
  output logic            selfHit
);

  logic flatHit;
  logic clusterHit;

  always_comb begin
    physHit    = (physId == msgDest[ID_W-1:0]);
    selfHit    = (physId == senderId);
    flatHit    = |(logDest & msgDest);
    clusterHit = (logDest[7:4] == msgDest[7:4]) && (|(logDest[3:0] & msgDest[3:0]));
    unique case (model)
      MODEL_FLAT:    logHit = flatHit;
      MODEL_CLUSTER: logHit = clusterHit;
      default:       logHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msgValid,
  input  logic [2:0] msgMode,
  input  logic       msgLevel,
  input  logic       msgTrigger,
  output routeCtrl_t ctrl,
  output logic       outValid
);

  delivMode_e mode;

  always_comb begin
    mode            = delivMode_e'(msgMode);
    ctrl.load       = msgValid;
    ctrl.pickLowest = (mode == DM_LOWEST);
    ctrl.resyncOnly = (mode == DM_INIT) && !msgLevel && msgTrigger;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= msgValid;
  end

endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  routeCtrl_t                 ctrl,
  input  logic [NUM_AGENTS*ID_W-1:0] agentPhysId,
  input  logic [NUM_AGENTS*8-1:0]    agentLogDest,
  input  logic [NUM_AGENTS*4-1:0]    agentModel,
  input  logic [7:0]                 msgDest,
  input  logic                       msgLogical,
  input  logic [1:0]                 msgShorthand,
  input  logic [ID_W-1:0]            senderId,
  output logic [NUM_AGENTS-1:0]      targetMask,
  output logic [NUM_AGENTS-1:0]      singleTarget,
  output logic [NUM_AGENTS-1:0]      resyncMask
);

  typedef logic [NUM_AGENTS-1:0] agentVec_t;

  agentVec_t physHit, logHit, selfHit;
  agentVec_t physSel, destSel, shSel, lowSel;
  agentVec_t nextTarget, nextSingle, nextResync;
  logic      broadcast;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    irq_agent_match #(.ID_W(ID_W)) u_match (
      .physId  (agentPhysId[i*ID_W +: ID_W]),
      .logDest (agentLogDest[i*8 +: 8]),
      .model   (agentModel[i*4 +: 4]),
      .msgDest (msgDest),
      .senderId(senderId),
      .physHit (physHit[i]),
      .logHit  (logHit[i]),
      .selfHit (selfHit[i])
    );
  end

  always_comb begin
    broadcast = &msgDest;
    physSel   = physHit & (~physHit + agentVec_t'(1));
    if (msgLogical)     destSel = logHit;
    else if (broadcast) destSel = '1;
    else                destSel = physSel;

    unique case (shorthand_e'(msgShorthand))
      SH_NONE:   shSel = destSel;
      SH_SELF:   shSel = selfHit;
      SH_ALL:    shSel = '1;
      SH_OTHERS: shSel = ~selfHit;
      default:   shSel = destSel;
    endcase

    lowSel     = shSel & (~shSel + agentVec_t'(1));
    nextTarget = shSel;
    nextSingle = '0;
    nextResync = '0;
    if (ctrl.resyncOnly) begin
      nextTarget = '0;
      nextResync = shSel;
    end else if (ctrl.pickLowest) begin
      nextTarget = lowSel;
      nextSingle = lowSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctrl.load) begin
      targetMask   <= '0;
      singleTarget <= '0;
      resyncMask   <= '0;
    end else begin
      targetMask   <= nextTarget;
      singleTarget <= nextSingle;
      resyncMask   <= nextResync;
    end
  end

endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_AGENTS*ID_W-1:0] agentPhysId,
  input  logic [NUM_AGENTS*8-1:0]    agentLogDest,
  input  logic [NUM_AGENTS*4-1:0]    agentModel,
  input  logic                       msgValid,
  input  logic [7:0]                 msgDest,
  input  logic                       msgLogical,
  input  logic [1:0]                 msgShorthand,
  input  logic [ID_W-1:0]            senderId,
  input  logic [2:0]                 msgMode,
  input  logic                       msgLevel,
  input  logic                       msgTrigger,
  output logic                       outValid,
  output logic [NUM_AGENTS-1:0]      targetMask,
  output logic [NUM_AGENTS-1:0]      singleTarget,
  output logic [NUM_AGENTS-1:0]      resyncMask
);

  routeCtrl_t ctrl;

  irq_route_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgValid  (msgValid),
    .msgMode   (msgMode),
    .msgLevel  (msgLevel),
    .msgTrigger(msgTrigger),
    .ctrl      (ctrl),
    .outValid  (outValid)
  );

  irq_route_datapath #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .agentPhysId (agentPhysId),
    .agentLogDest(agentLogDest),
    .agentModel  (agentModel),
    .msgDest     (msgDest),
    .msgLogical  (msgLogical),
    .msgShorthand(msgShorthand),
    .senderId    (senderId),
    .targetMask  (targetMask),
    .singleTarget(singleTarget),
    .resyncMask  (resyncMask)
  );

endmodule

// File: rtl/intr_dest_resolver_chk.sv
module intr_dest_resolver_chk #(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  msgValid,
  input logic [7:0]            msgDest,
  input logic                  msgLogical,
  input logic [1:0]            msgShorthand,
  input logic [2:0]            msgMode,
  input logic                  outValid,
  input logic [NUM_AGENTS-1:0] targetMask,
  input logic [NUM_AGENTS-1:0] singleTarget,
  input logic [NUM_AGENTS-1:0] resyncMask
);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> outValid);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (targetMask == '0 && singleTarget == '0 && resyncMask == '0));

  p_single_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(singleTarget));

  p_single_in_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (singleTarget != '0) |-> (targetMask == singleTarget));

  p_resync_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resyncMask != '0) |-> (targetMask == '0 && singleTarget == '0));

  p_broadcast_r1: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgLogical && msgShorthand == 2'd0 && msgMode == 3'd0 && (&msgDest))
      |=> (&targetMask));

  p_all_shorthand_r6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShorthand == 2'd2 && msgMode == 3'd0) |=> (&targetMask));

endmodule

bind intr_dest_resolver intr_dest_resolver_chk #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .msgValid    (msgValid),
  .msgDest     (msgDest),
  .msgLogical  (msgLogical),
  .msgShorthand(msgShorthand),
  .msgMode     (msgMode),
  .outValid    (outValid),
  .targetMask  (targetMask),
  .singleTarget(singleTarget),
  .resyncMask  (resyncMask)
);

// File: tb/intr_dest_resolver_test.sv
`timescale 1ns/1ps
module intr_dest_resolver_test;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*8-1:0] physIds  = '0;
  logic [N*8-1:0] logDests = '0;
  logic [N*4-1:0] models   = '0;
  logic       msgValid = 1'b0;
  logic [7:0] msgDest = '0;
  logic       msgLogical = 1'b0;
  logic [1:0] msgShorthand = '0;
  logic [7:0] senderId = '0;
  logic [2:0] msgMode = '0;
  logic       msgLevel = 1'b0;
  logic       msgTrigger = 1'b0;
  logic           outValid;
  logic [N-1:0]   targetMask, singleTarget, resyncMask;

  int checks = 0;
  int errors = 0;

  logic         expValid = 1'b0;
  logic [N-1:0] expTarget = '0, expSingle = '0, expResync = '0;
  string        expTag = "R10";

  always #2 clk = ~clk;

  intr_dest_resolver #(.NUM_AGENTS(N), .ID_W(8)) uut (
    .clk(clk), .rstN(rstN),
    .agentPhysId(physIds), .agentLogDest(logDests), .agentModel(models),
    .msgValid(msgValid), .msgDest(msgDest), .msgLogical(msgLogical),
    .msgShorthand(msgShorthand), .senderId(senderId), .msgMode(msgMode),
    .msgLevel(msgLevel), .msgTrigger(msgTrigger),
    .outValid(outValid), .targetMask(targetMask),
    .singleTarget(singleTarget), .resyncMask(resyncMask)
  );

  // behavioural reference of the requirements
  task automatic model_msg();
    logic [N-1:0] sel;
    int firstHit;
    sel = '0;
    firstHit = -1;
    for (int i = 0; i < N; i++) begin
      logic [7:0] id, ld;
      logic [3:0] md;
      id = physIds[i*8 +: 8];
      ld = logDests[i*8 +: 8];
      md = models[i*4 +: 4];
      if (!msgLogical) begin
        if (msgDest == 8'hFF) sel[i] = 1'b1;
        else if (id == msgDest && firstHit < 0) firstHit = i;
      end else if (md == 4'hF) begin
        sel[i] = (ld & msgDest) != 0;
      end else if (md == 4'h0) begin
        sel[i] = (ld[7:4] == msgDest[7:4]) && ((ld[3:0] & msgDest[3:0]) != 0);
      end
    end
    if (firstHit >= 0) sel[firstHit] = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (msgShorthand == 2'd1) sel[i] = (physIds[i*8 +: 8] == senderId);
      if (msgShorthand == 2'd2) sel[i] = 1'b1;
      if (msgShorthand == 2'd3) sel[i] = (physIds[i*8 +: 8] != senderId);
    end
    expValid  = msgValid;
    expTarget = '0;
    expSingle = '0;
    expResync = '0;
    if (msgValid) begin
      if (msgMode == 3'd5 && !msgLevel && msgTrigger) expResync = sel;
      else if (msgMode == 3'd1) begin
        for (int i = N - 1; i >= 0; i--) if (sel[i]) expSingle = '0 | (1 << i);
        expTarget = expSingle;
      end else expTarget = sel;
    end
  endtask

  task automatic compare();
    checks++;
    if (outValid !== expValid || targetMask !== expTarget ||
        singleTarget !== expSingle || resyncMask !== expResync) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%h s=%h r=%h exp v=%0b t=%h s=%h r=%h", expTag,
               outValid, targetMask, singleTarget, resyncMask,
               expValid, expTarget, expSingle, expResync);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic lg,
                      input logic [1:0] sh, input logic [7:0] snd,
                      input logic [2:0] md, input logic lv, input logic tr,
                      input string tag);
    @(negedge clk);
    compare();
    msgValid = v; msgDest = d; msgLogical = lg; msgShorthand = sh;
    senderId = snd; msgMode = md; msgLevel = lv; msgTrigger = tr;
    model_msg();
    expTag = tag;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // phase A configuration
    for (int i = 0; i < N; i++) physIds[i*8 +: 8] = 8'h10 + 8'(i);
    physIds[6*8 +: 8] = 8'h12;                    // duplicate of agent 2
    for (int i = 0; i < 4; i++) begin
      logDests[i*8 +: 8] = 8'(1 << i);
      models[i*4 +: 4] = 4'hF;
    end
    logDests[4*8 +: 8] = 8'h31; models[4*4 +: 4] = 4'h0;
    logDests[5*8 +: 8] = 8'h32; models[5*4 +: 4] = 4'h0;
    logDests[6*8 +: 8] = 8'h52; models[6*4 +: 4] = 4'h0;
    logDests[7*8 +: 8] = 8'hFF; models[7*4 +: 4] = 4'h5;

    // R10: reset state, even with a message presented
    msgValid = 1'b1; msgDest = 8'hFF;
    repeat (3) begin @(negedge clk); compare(); end
    msgValid = 1'b0;
    @(negedge clk); compare();
    rstN = 1'b1;
    model_msg();

    step(1, 8'hFF, 0, 0, 8'h10, 0, 0, 0, "R1");
    step(1, 8'h12, 0, 0, 8'h10, 0, 0, 0, "R2");   // lowest index of duplicate
    step(1, 8'h99, 0, 0, 8'h10, 0, 0, 0, "R2");   // no match
    step(1, 8'h05, 1, 0, 8'h10, 0, 0, 0, "R3");
    step(1, 8'h33, 1, 0, 8'h10, 0, 0, 0, "R4");
    step(1, 8'hFF, 1, 0, 8'h10, 0, 0, 0, "R5");   // agent 7 never
    step(1, 8'h00, 0, 1, 8'h13, 0, 0, 0, "R6");
    step(1, 8'h00, 0, 2, 8'h13, 0, 0, 0, "R6");
    step(1, 8'h00, 0, 3, 8'h13, 0, 0, 0, "R6");
    step(1, 8'hFF, 0, 0, 8'h10, 1, 0, 0, "R7");
    step(1, 8'h32, 1, 0, 8'h10, 1, 0, 0, "R7");
    step(1, 8'h99, 0, 0, 8'h10, 1, 0, 0, "R7");   // empty, valid still pulses
    step(1, 8'h00, 0, 3, 8'h10, 1, 0, 0, "R7");   // shorthand + lowest together
    step(1, 8'h00, 0, 3, 8'h10, 5, 0, 1, "R8");   // shorthand + resync together
    step(1, 8'hFF, 0, 0, 8'h10, 5, 1, 1, "R8");   // INIT assert: delivered
    step(1, 8'hFF, 0, 0, 8'h10, 4, 0, 1, "R8");
    step(0, 8'hFF, 0, 0, 8'h10, 0, 0, 0, "R9");   // idle after back-to-back
    step(0, 8'hFF, 0, 2, 8'h10, 1, 0, 0, "R9");

    // phase B: random configurations and messages
    for (int k = 0; k < 400; k++) begin
      logic [1:0] sh;
      logic [2:0] md;
      logic lg, lv, tr;
      string tg;
      if (k % 50 == 0) begin
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
          physIds[i*8 +: 8]  = 8'h10 + 8'($urandom_range(0, 7));
          logDests[i*8 +: 8] = 8'($urandom);
          case ($urandom_range(0, 2))
            0: models[i*4 +: 4] = 4'hF;
            1: models[i*4 +: 4] = 4'h0;
            default: models[i*4 +: 4] = 4'h9;
          endcase
        end
        compare();
        model_msg();
      end
      sh = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0;
      md = 3'($urandom);
      lg = 1'($urandom);
      lv = 1'($urandom);
      tr = 1'($urandom);
      if (sh != 0) tg = "R6";
      else if (md == 3'd1) tg = "R7";
      else if (md == 3'd5) tg = "R8";
      else if (lg) tg = "R3";
      else tg = "R2";
      step(($urandom_range(0, 4) != 0) ? 1'b1 : 1'b0,
           ($urandom_range(0, 5) == 0) ? 8'hFF : 8'h10 + 8'($urandom_range(0, 9)),
           lg, sh, 8'h10 + 8'($urandom_range(0, 7)), md, lv, tr, tg);
    end
    step(0, 8'h00, 0, 0, 8'h10, 0, 0, 0, "R9");
    @(negedge clk); compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule